// File: doc/BRIEF.md
# Multi-Rail Reset Supervisor Sequencer

This block turns three digitized supply-comparator flags into three reset outputs. The main rail drives an active-high reset. That reset asserts as soon as the main flag reports a fault. It stays asserted for a programmable hold time after the rail becomes good again. A manual reset pin can also force it, and the same hold time follows the release of that pin. The two auxiliary rails each drive a monitor output that simply mirrors its comparator: high while the rail is good, low while it is not. These outputs have no stretching.

All four asynchronous inputs pass through a two-flop synchronizer. A three-state machine controls the main reset. In ST_FAULT the output is asserted and the hold counter reloads every cycle. In ST_STRETCH the output is still asserted while the counter runs down. In ST_RUN the output is released. The transitions are:
- ST_FAULT goes to ST_STRETCH on the first cycle with no fault.
- ST_STRETCH goes to ST_RUN when the counter finishes its last count.
- ST_STRETCH returns to ST_FAULT on any fault.
- ST_RUN returns to ST_FAULT on any fault.

A fault means the main flag is low or the manual pin is high. A 2-bit select field picks one of four hold counts, and the count is sampled only on reload.

Top module: `rail_reset_sequencer`

## Requirements
- R1: While the block reset is low, and after it releases until the hold time has elapsed, main_rst_o is 1. The auxiliary outputs are 0 during block reset.
- R2: When main_ok_i falls while main_rst_o is 0, main_rst_o is still 0 after the 2nd rising edge and is 1 after the 3rd rising edge.
- R3: The release timing is measured from when main_ok_i is 1 and man_rst_i is 0 and both stay so. main_rst_o is 1 after the (N+2)th rising edge and 0 after the (N+3)th, where N is the selected hold count. Select code 00 gives N=16.
- R4: Select codes 01, 10 and 11 give N = 64, 256 and 1024 with the same timing as R3.
- R5: man_rst_i high asserts main_rst_o with the R2 latency even when main_ok_i is 1. After man_rst_i returns low, release follows the R3 timing.
- R6: A fault of a single cycle during the hold time restarts the full hold count, timed from the end of that fault.
- R7: Changing hold_sel_i during a countdown does not alter that countdown. The new code applies at the next reload.
- R8: Each auxiliary output equals its comparator input delayed by two rising edges, with no stretching. It is independent of main_rst_o and of the other auxiliary output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| main_ok_i | input | 1 | Main rail comparator flag, 1 = above trip level |
| aux1_ok_i | input | 1 | First auxiliary comparator flag, 1 = above trip level |
| aux2_ok_i | input | 1 | Second auxiliary comparator flag, 1 = above trip level |
| man_rst_i | input | 1 | Manual reset request, active high |
| hold_sel_i | input | 2 | Hold-time select code (00/01/10/11) |
| main_rst_o | output | 1 | Stretched main reset, active high |
| aux1_rst_o | output | 1 | First auxiliary monitor output, high when rail good |
| aux2_rst_o | output | 1 | Second auxiliary monitor output, high when rail good |

## Verification
The bench pins the release edge to an exact cycle for every select code. An off-by-one counter, or a counter that skips the load cycle, would release one cycle early or late. A one-cycle fault is injected midway through a hold. A design that only paused its counter, instead of reloading it, would release too soon. The select code is changed mid-countdown to catch a design that reads the select continuously rather than latching it on reload. The auxiliary outputs are toggled while the main reset is both held and released, to expose any stretching or coupling between the rails.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic [1:0] {
        ST_FAULT   = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } sup_state_t;
endpackage

// File: rtl/rrs_sync.sv
module rrs_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rrs_hold_timer.sv
module rrs_hold_timer #(
    parameter int unsigned HOLD_00 = 16,
    parameter int unsigned HOLD_01 = 64,
    parameter int unsigned HOLD_10 = 256,
    parameter int unsigned HOLD_11 = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_i,
    input  logic       load_i,
    input  logic       dec_i,
    output logic       last_o,
    output logic       zero_o
);
    localparam int unsigned MAX_A = (HOLD_00 > HOLD_01) ? HOLD_00 : HOLD_01;
    localparam int unsigned MAX_B = (HOLD_10 > HOLD_11) ? HOLD_10 : HOLD_11;
    localparam int unsigned MAX_H = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int          CW    = $clog2(MAX_H + 1);

    logic [CW-1:0] reload;
    logic [CW-1:0] cnt_q;

    always_comb begin
        unique case (sel_i)
            2'b00:   reload = CW'(HOLD_00);
            2'b01:   reload = CW'(HOLD_01);
            2'b10:   reload = CW'(HOLD_10);
            default: reload = CW'(HOLD_11);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= reload;
        end else if (dec_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == CW'(1));
    assign zero_o = (cnt_q == '0);

    // R3
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !zero_o);
endmodule

// File: rtl/rrs_main_fsm.sv
module rrs_main_fsm
    import rrs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    input  logic cnt_last_i,
    input  logic cnt_zero_i,
    output logic load_o,
    output logic dec_o,
    output logic main_rst_o
);
    sup_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FAULT:   if (!fault_i) state_d = ST_STRETCH;
            ST_STRETCH: if (fault_i) state_d = ST_FAULT;
                        else if (cnt_last_i) state_d = ST_RUN;
            ST_RUN:     if (fault_i) state_d = ST_FAULT;
            default:    state_d = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FAULT;
        else        state_q <= state_d;
    end

    always_comb begin
        load_o     = 1'b0;
        dec_o      = 1'b0;
        main_rst_o = 1'b1;
        unique case (state_q)
            ST_FAULT:   load_o = 1'b1;
            ST_STRETCH: dec_o = 1'b1;
            ST_RUN:     main_rst_o = 1'b0;
            default:    load_o = 1'b1;
        endcase
    end

    // R2
    fault_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> main_rst_o);

    // R3
    release_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_STRETCH) |-> cnt_zero_i);
endmodule

// File: rtl/rail_reset_sequencer.sv
module rail_reset_sequencer #(
    parameter int unsigned HOLD_00 = 16,
    parameter int unsigned HOLD_01 = 64,
    parameter int unsigned HOLD_10 = 256,
    parameter int unsigned HOLD_11 = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_ok_i,
    input  logic       aux1_ok_i,
    input  logic       aux2_ok_i,
    input  logic       man_rst_i,
    input  logic [1:0] hold_sel_i,
    output logic       main_rst_o,
    output logic       aux1_rst_o,
    output logic       aux2_rst_o
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] raw_bus, sync_bus;
    logic main_ok_s, aux1_s, aux2_s, man_s;
    logic fault, load, dec, cnt_last, cnt_zero;

    assign raw_bus = {man_rst_i, aux2_ok_i, aux1_ok_i, main_ok_i};

    rrs_sync #(.WIDTH(NSYNC), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_bus),
        .q_o   (sync_bus)
    );

    assign {man_s, aux2_s, aux1_s, main_ok_s} = sync_bus;
    assign fault = !main_ok_s || man_s;

    rrs_hold_timer #(
        .HOLD_00(HOLD_00), .HOLD_01(HOLD_01),
        .HOLD_10(HOLD_10), .HOLD_11(HOLD_11)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (hold_sel_i),
        .load_i (load),
        .dec_i  (dec),
        .last_o (cnt_last),
        .zero_o (cnt_zero)
    );

    rrs_main_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_i    (fault),
        .cnt_last_i (cnt_last),
        .cnt_zero_i (cnt_zero),
        .load_o     (load),
        .dec_o      (dec),
        .main_rst_o (main_rst_o)
    );

    assign aux1_rst_o = aux1_s;
    assign aux2_rst_o = aux2_s;

    // R5
    no_release_in_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(main_rst_o) |-> !$past(man_s));

    // R8
    aux1_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux1_rst_o) |-> $past(aux1_ok_i, 2));

    // R8
    aux2_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aux2_rst_o) |-> !$past(aux2_ok_i, 2));
endmodule

// File: tb/sim_rail_reset_sequencer.sv
module sim_rail_reset_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_ok = 1'b1;
    logic       aux1_ok = 1'b1;
    logic       aux2_ok = 1'b1;
    logic       man_rst = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       main_rst, aux1_rst, aux2_rst;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rail_reset_sequencer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .main_ok_i  (main_ok),
        .aux1_ok_i  (aux1_ok),
        .aux2_ok_i  (aux2_ok),
        .man_rst_i  (man_rst),
        .hold_sel_i (sel),
        .main_rst_o (main_rst),
        .aux1_rst_o (aux1_rst),
        .aux2_rst_o (aux2_rst)
    );

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic expect_release(int n, string tag);
        step(n + 2);
        chk(tag, main_rst, 1'b1);
        step(1);
        chk(tag, main_rst, 1'b0);
    endtask

    task automatic enter_fault(logic [1:0] code, string tag);
        main_ok = 1'b0;
        sel = code;
        step(2);
        chk(tag, main_rst, 1'b0);
        step(1);
        chk(tag, main_rst, 1'b1);
        step(2);
        main_ok = 1'b1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 main in reset", main_rst, 1'b1);
        chk("R1 aux1 in reset", aux1_rst, 1'b0);
        chk("R1 aux2 in reset", aux2_rst, 1'b0);
        step(3);
        chk("R1 main held in reset", main_rst, 1'b1);
        rst_n = 1'b1;
        expect_release(16, "R1 R3 release after reset");
    endtask

    task automatic t_codes;
        enter_fault(2'b01, "R2 fault entry");
        expect_release(64, "R4 code 01");
        enter_fault(2'b10, "R2 fault entry");
        expect_release(256, "R4 code 10");
        enter_fault(2'b11, "R2 fault entry");
        expect_release(1024, "R4 code 11");
    endtask

    task automatic t_manual;
        sel = 2'b00;
        man_rst = 1'b1;
        step(2);
        chk("R5 manual latency", main_rst, 1'b0);
        step(1);
        chk("R5 manual asserts", main_rst, 1'b1);
        step(6);
        chk("R5 manual held", main_rst, 1'b1);
        man_rst = 1'b0;
        expect_release(16, "R5 manual release");
    endtask

    task automatic t_restart;
        enter_fault(2'b00, "R2 fault entry");
        step(8);
        main_ok = 1'b0;
        step(1);
        main_ok = 1'b1;
        expect_release(16, "R6 restart after glitch");
    endtask

    task automatic t_sel_change;
        enter_fault(2'b00, "R2 fault entry");
        step(5);
        sel = 2'b11;
        step(16 + 2 - 5);
        chk("R7 countdown unchanged", main_rst, 1'b1);
        step(1);
        chk("R7 countdown unchanged", main_rst, 1'b0);
        main_ok = 1'b0;
        step(5);
        main_ok = 1'b1;
        expect_release(1024, "R7 new code on reload");
    endtask

    task automatic t_aux;
        aux1_ok = 1'b0;
        step(1);
        chk("R8 aux1 latency", aux1_rst, 1'b1);
        step(1);
        chk("R8 aux1 falls", aux1_rst, 1'b0);
        chk("R8 aux2 independent", aux2_rst, 1'b1);
        chk("R8 main independent", main_rst, 1'b0);
        aux1_ok = 1'b1;
        step(2);
        chk("R8 aux1 rises no stretch", aux1_rst, 1'b1);
        main_ok = 1'b0;
        aux2_ok = 1'b0;
        step(2);
        chk("R8 aux2 falls", aux2_rst, 1'b0);
        aux2_ok = 1'b1;
        step(2);
        chk("R8 aux2 rises during main fault", aux2_rst, 1'b1);
        chk("R8 main still faulted", main_rst, 1'b1);
        main_ok = 1'b1;
        step(30);
    endtask

    initial begin
        t_reset();
        t_codes();
        t_manual();
        t_restart();
        t_sel_change();
        t_aux();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule